// File: doc/BRIEF.md
# Standby Wakeup Flag Logic

This block watches a set of asynchronous wakeup pins and keeps one sticky wakeup flag that a power controller reads to decide when to leave standby. Each pin has its own enable bit and its own trigger-mode bit, which are loaded together through a single configuration write strobe. Software drops the flag with a one-cycle clear strobe, and the block drives a wake request whenever the power controller signals that standby is active and the flag is set.

Every pin is brought into the clock domain by a two-stage synchroniser and gets its own rising-edge detector. The OR of the qualified events comes after these detectors. A pin that stays high across a clear therefore cannot hide a later rise on another pin. In level mode a pin that is high and enabled keeps setting the flag. The block also reports whether entering standby now would end in an immediate wakeup.

Top module: `wkup_flag`

## Requirements
- R1: After reset the flag, the wake request and the immediate-wake output are 0 and all enables and mode bits are 0.
- R2: In edge mode a 0-to-1 change on an enabled pin, applied between clock edges, sets the flag on the third rising clock edge after the change and not before.
- R3: A rising pin whose enable bit is 0 leaves the flag unchanged.
- R4: A clear strobe with no set event in the same cycle makes the flag 0 on the next rising edge.
- R5: When a set event and a clear strobe fall in the same cycle, the flag is 1 after that edge.
- R6: A pin held high across a clear does not keep a later rising edge on any other enabled pin from setting the flag.
- R7: In edge mode, enabling a pin that is already high does not set the flag.
- R8: In level mode (mode bit 1), an enabled pin that is high sets the flag on every cycle, so a clear strobe does not drop the flag while that pin stays high.
- R9: The wake request output equals the flag ANDed with the standby input.
- R10: The immediate-wake output is 1 when the flag is 1 or when some enabled level-mode pin is high after synchronisation; an edge-mode pin held high does not raise it.
- R11: Once set, the flag stays 1 until a clear strobe, even after every pin returns low.
- R12: A configuration write strobe loads the enable bits and the mode bits on the next rising edge; without it they hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wk_pin | input | NUM_SRC | Asynchronous wakeup pins |
| cfg_wr | input | 1 | Load strobe for enables and mode bits |
| cfg_en | input | NUM_SRC | Per-pin enable value to load |
| cfg_lvl | input | NUM_SRC | Per-pin mode value to load (1 = level, 0 = edge) |
| clr_stb | input | 1 | One-cycle flag clear strobe |
| stby | input | 1 | Standby is active |
| flag | output | 1 | Sticky wakeup flag |
| wake_req | output | 1 | Wake request to the power controller |
| imm_wake | output | 1 | Standby entry would wake at once |

## Verification
The main function is driven with a single pin rising, a rise on a disabled pin, a pin that rose before it was enabled, and a rise on one pin while another pin stays high through a clear. Together these separate a per-pin edge detector from a shared one behind the OR, and an edge from a change in configuration. Clear strobes are placed both alone and in the same cycle as a set event, which shows which one wins. Level-mode pins are compared with edge-mode pins held high, both through the flag after a clear and through the immediate-wake output.

// File: rtl/wkup_flag.sv
module wkup_flag #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] wk_pin,
  input  logic               cfg_wr,
  input  logic [NUM_SRC-1:0] cfg_en,
  input  logic [NUM_SRC-1:0] cfg_lvl,
  input  logic               clr_stb,
  input  logic               stby,
  output logic               flag,
  output logic               wake_req,
  output logic               imm_wake
);

  logic [NUM_SRC-1:0] meta_q, sync_q, prev_q;
  logic [NUM_SRC-1:0] en_q, lvl_q;
  logic [NUM_SRC-1:0] rise, hit;
  logic               set_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= wk_pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      lvl_q <= '0;
    end else if (cfg_wr) begin
      en_q  <= cfg_en;
      lvl_q <= cfg_lvl;
    end
  end

  // per-pin detection ahead of the OR
  assign rise    = sync_q & ~prev_q;
  assign hit     = en_q & ((lvl_q & sync_q) | (~lvl_q & rise));
  assign set_any = |hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (set_any)  flag <= 1'b1;
    else if (clr_stb)  flag <= 1'b0;
  end

  assign wake_req = stby & flag;
  assign imm_wake = flag | (|(en_q & lvl_q & sync_q));

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_any |=> flag);

  p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !set_any) |=> !flag);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_stb) |=> flag);

  p_no_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0 && !flag) |=> !flag);

  p_cfg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> ($stable(en_q) && $stable(lvl_q)));

endmodule

// File: tb/wkup_flag_tb.sv
module wkup_flag_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] wk_pin = '0;
  logic         cfg_wr = 1'b0;
  logic [N-1:0] cfg_en = '0;
  logic [N-1:0] cfg_lvl = '0;
  logic         clr_stb = 1'b0;
  logic         stby = 1'b0;
  logic         flag, wake_req, imm_wake;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cyc = 0;

  wkup_flag #(.NUM_SRC(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .wk_pin(wk_pin), .cfg_wr(cfg_wr),
    .cfg_en(cfg_en), .cfg_lvl(cfg_lvl), .clr_stb(clr_stb), .stby(stby),
    .flag(flag), .wake_req(wake_req), .imm_wake(imm_wake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // advance n rising edges, stop at the following falling edge
  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wk_pin = '0; cfg_wr = 0; cfg_en = '0; cfg_lvl = '0;
    clr_stb = 0; stby = 0;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  task automatic configure(logic [N-1:0] en, logic [N-1:0] lvl);
    cfg_wr = 1; cfg_en = en; cfg_lvl = lvl;
    step(1);
    cfg_wr = 0; cfg_en = '0; cfg_lvl = '0;
  endtask

  task automatic clear();
    clr_stb = 1;
    step(1);
    clr_stb = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 flag", flag, 0);
    chk("R1 wake_req", wake_req, 0);
    chk("R1 imm_wake", imm_wake, 0);
    wk_pin = '1;
    step(6);
    chk("R1 enables zero after reset", flag, 0);
  endtask

  task automatic t_edge();
    do_reset();
    configure(4'b0001, 4'b0000);
    wk_pin[0] = 1;
    step(2);
    chk("R2 not before third edge", flag, 0);
    step(1);
    chk("R2 set on third edge", flag, 1);
    wk_pin[0] = 0;
    step(5);
    chk("R11 sticky after pin low", flag, 1);
    chk("R9 no standby", wake_req, 0);
    stby = 1;
    #1;
    chk("R9 standby and flag", wake_req, 1);
    clear();
    chk("R4 clear", flag, 0);
    chk("R9 flag low", wake_req, 0);
    stby = 0;
  endtask

  task automatic t_disabled();
    do_reset();
    configure(4'b0001, 4'b0000);
    wk_pin[1] = 1;
    step(6);
    chk("R3 disabled pin ignored", flag, 0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    configure(4'b0011, 4'b0000);
    wk_pin[0] = 1;
    step(3);
    chk("R5 setup", flag, 1);
    wk_pin[1] = 1;
    step(2);
    clear();
    chk("R5 set beats clear", flag, 1);
    step(2);
    chk("R5 stays set", flag, 1);
  endtask

  task automatic t_held_high();
    do_reset();
    configure(4'b0011, 4'b0000);
    wk_pin[0] = 1;
    step(3);
    chk("R6 setup", flag, 1);
    clear();
    chk("R6 cleared with pin high", flag, 0);
    step(4);
    chk("R10 edge pin high no imm", imm_wake, 0);
    chk("R6 held pin no reset", flag, 0);
    wk_pin[1] = 1;
    step(3);
    chk("R6 other pin still wakes", flag, 1);
  endtask

  task automatic t_enable_high();
    do_reset();
    wk_pin[2] = 1;
    step(4);
    configure(4'b0100, 4'b0000);
    step(5);
    chk("R7 enable of high pin", flag, 0);
    chk("R12 enable loaded", imm_wake, 0);
    wk_pin[2] = 0;
    step(4);
    wk_pin[2] = 1;
    step(3);
    chk("R12 enable took effect", flag, 1);
  endtask

  task automatic t_level();
    do_reset();
    wk_pin[3] = 1;
    step(4);
    configure(4'b1000, 4'b1000);
    chk("R10 level pin imm", imm_wake, 1);
    step(1);
    chk("R8 level sets", flag, 1);
    clear();
    chk("R8 clear held off", flag, 1);
    wk_pin[3] = 0;
    step(3);
    clear();
    chk("R8 clear after low", flag, 0);
    chk("R10 imm low", imm_wake, 0);
  endtask

  initial begin
    t_reset();
    t_edge();
    t_disabled();
    t_same_cycle();
    t_held_high();
    t_enable_high();
    t_level();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule